// File: doc/BRIEF.md
# Multi-Mode Preset Timer Channel

This block is one hardware timer channel of the kind a sequencing controller uses to delay, stretch or total up a condition. A one-bit rung condition arms it, a one-clock tick strobe (one strobe per millisecond in the intended system) sets its time base, and a preset gives the target in tick units. A preset of 10 therefore means ten ticks, not ten seconds. The channel reports its accumulated tick count and three status flags: enabled, timing and done.

The behaviour is picked by a two-bit mode input. The mode is taken only while reset is held, so it cannot change while the channel runs. In delay-on mode the channel counts while the condition holds and asserts done on reaching the preset. In delay-off mode, done follows the condition at once and is held for the preset time after the condition drops. In accumulate mode the count survives condition drops and only an explicit clear pulse removes it. The accumulator stops at the preset and never wraps.

All outputs are registered. An input sampled at a rising clock edge is visible on the outputs after that edge.

Top module: `preset_timer`

## Requirements
- R1: In delay-on mode (mode 00), each clock edge that samples the condition and the tick both high raises the accumulator by one. Done is 1 once the accumulator is at or above the preset.
- R2: In delay-on mode, an edge that samples the condition low clears the accumulator, done and timing to 0. A condition pulse shorter than the preset therefore never produces done.
- R3: In delay-off mode (mode 01), the condition high gives done 1 and an accumulator of 0. After the condition falls, ticks advance the accumulator, and done clears on the edge where the accumulator reaches the preset.
- R4: In delay-off mode, a condition rise during the run-down clears the accumulator to 0, and done stays 1.
- R5: In accumulate mode (mode 10), the accumulator holds its value while the condition is low and resumes from that value when it returns. Done, once set, stays set while the condition is low.
- R6: The clear input zeroes the accumulator and done in accumulate mode, taking priority over the condition. In delay-on and delay-off modes it has no effect on any output.
- R7: Timing is 1 only while the accumulator is still counting toward the preset: condition high and below the preset in delay-on and accumulate modes, run-down in progress in delay-off mode. It is 0 otherwise.
- R8: The enabled flag equals the condition sampled at the previous clock edge.
- R9: The accumulator stops at the preset. Further ticks leave it unchanged and it never wraps.
- R10: The mode is captured only while reset is low. Mode 11 behaves as delay-on. A mode change after reset has no effect.
- R11: After reset the accumulator, enabled, timing and done outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; mode is captured while low |
| mode_sel | input | 2 | 00 delay-on, 01 delay-off, 10 accumulate, 11 delay-on |
| cond_i | input | 1 | Rung condition enabling the timer |
| clr_i | input | 1 | Clear pulse for the accumulate mode |
| tick_i | input | 1 | Time-base strobe, one clock wide |
| preset_i | input | 32 | Target count in ticks |
| acc_o | output | 32 | Accumulated tick count |
| en_o | output | 1 | Enabled flag |
| tt_o | output | 1 | Timing flag |
| dn_o | output | 1 | Done flag |

## Verification
The bench targets the corner cases a wrong design would get wrong. It drops the condition one tick short of the preset: a design that held the count would later reach done on a short pulse. It retriggers the delay-off run-down: a design that dropped done there, or kept the partial count, would shorten the stretch. It parks an accumulate-mode count and fires the clear in the other modes: a design that leaked the retention or the clear across modes would lose or corrupt counts. It also checks saturation after extra ticks, mode 11, and mode changes outside reset, where a wrapping accumulator or a live mode decode would show up at once.

// File: rtl/preset_timer_pkg.sv
package preset_timer_pkg;

    typedef enum logic [1:0] {
        TM_DELAY_ON  = 2'b00,
        TM_DELAY_OFF = 2'b01,
        TM_ACCUM     = 2'b10
    } tm_mode_e;

    function automatic tm_mode_e tm_decode(input logic [1:0] raw);
        case (raw)
            2'b01:   return TM_DELAY_OFF;
            2'b10:   return TM_ACCUM;
            default: return TM_DELAY_ON;
        endcase
    endfunction

endpackage

// File: rtl/tm_mode_latch.sv
module tm_mode_latch
    import preset_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    output tm_mode_e   mode_o
);
    tm_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (!rst_n) mode_d = tm_decode(mode_sel);
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    assign mode_o = mode_q;

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mode_q)) else $error("mode changed outside reset"); // R10
endmodule

// File: rtl/tm_step.sv
module tm_step #(
    parameter int ACC_W = 32
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] preset_i,
    input  logic             adv_i,
    output logic [ACC_W-1:0] acc_nx_o,
    output logic             reached_o
);
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1);

    logic below;

    always_comb begin
        below    = acc_i < preset_i;
        acc_nx_o = (adv_i && below) ? acc_i + ONE : acc_i;
        reached_o = acc_nx_o >= preset_i;
    end
endmodule

// File: rtl/tm_core.sv
module tm_core
    import preset_timer_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tm_mode_e         mode_i,
    input  logic             cond_i,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [ACC_W-1:0] preset_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             en_o,
    output logic             tt_o,
    output logic             dn_o
);
    localparam logic [ACC_W-1:0] ZERO = '0;
    localparam logic [ACC_W-1:0] ONE  = ACC_W'(1);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             en;
        logic             tt;
        logic             dn;
    } tm_state_t;

    tm_state_t        st_d, st_q;
    logic [ACC_W-1:0] acc_nx;
    logic             reached;

    tm_step #(.ACC_W(ACC_W)) u_step (
        .acc_i     (st_q.acc),
        .preset_i  (preset_i),
        .adv_i     (tick_i),
        .acc_nx_o  (acc_nx),
        .reached_o (reached)
    );

    always_comb begin
        st_d    = st_q;
        st_d.en = cond_i;
        st_d.tt = 1'b0;
        case (mode_i)
            TM_DELAY_OFF: begin
                if (cond_i) begin
                    st_d.acc = ZERO;
                    st_d.dn  = 1'b1;
                end else if (st_q.dn) begin
                    st_d.acc = acc_nx;
                    st_d.dn  = !reached;
                    st_d.tt  = !reached;
                end else begin
                    st_d.dn  = 1'b0;
                end
            end
            TM_ACCUM: begin
                if (clr_i) begin
                    st_d.acc = ZERO;
                    st_d.dn  = 1'b0;
                end else if (cond_i) begin
                    st_d.acc = acc_nx;
                    st_d.dn  = st_q.dn || reached;
                    st_d.tt  = !reached;
                end
            end
            default: begin
                if (cond_i) begin
                    st_d.acc = acc_nx;
                    st_d.dn  = reached;
                    st_d.tt  = !reached;
                end else begin
                    st_d.acc = ZERO;
                    st_d.dn  = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = st_q.acc;
    assign en_o  = st_q.en;
    assign tt_o  = st_q.tt;
    assign dn_o  = st_q.dn;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (acc_o == ZERO || acc_o == $past(acc_o) || acc_o == $past(acc_o) + ONE))
        else $error("accumulator jumped"); // R1
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> (acc_o == ZERO || acc_o == $past(acc_o)))
        else $error("accumulator moved without tick"); // R9
    AST_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TM_DELAY_ON && !cond_i) |=> (acc_o == ZERO && !dn_o && !tt_o))
        else $error("delay-on not cleared"); // R2
    AST_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TM_DELAY_OFF && cond_i) |=> (dn_o && acc_o == ZERO))
        else $error("delay-off done not held"); // R4
    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TM_ACCUM && clr_i) |=> (acc_o == ZERO && !dn_o))
        else $error("accumulate clear failed"); // R6
    AST_TT_DN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != TM_DELAY_OFF) |-> !(tt_o && dn_o))
        else $error("timing and done together"); // R7
    AST_EN_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (en_o == $past(cond_i)))
        else $error("enabled flag mismatch"); // R8
endmodule

// File: rtl/preset_timer.sv
module preset_timer
    import preset_timer_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             cond_i,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [ACC_W-1:0] preset_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             en_o,
    output logic             tt_o,
    output logic             dn_o
);
    tm_mode_e mode;

    tm_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .mode_o   (mode)
    );

    tm_core #(.ACC_W(ACC_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .cond_i   (cond_i),
        .clr_i    (clr_i),
        .tick_i   (tick_i),
        .preset_i (preset_i),
        .acc_o    (acc_o),
        .en_o     (en_o),
        .tt_o     (tt_o),
        .dn_o     (dn_o)
    );
endmodule

// File: tb/sim_preset_timer.sv
`timescale 1ns/1ps
module sim_preset_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic        cond_i = 1'b0;
    logic        clr_i = 1'b0;
    logic        tick_i = 1'b0;
    logic [31:0] preset_i = 32'd0;
    logic [31:0] acc_o;
    logic        en_o, tt_o, dn_o;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    preset_timer u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cond_i(cond_i),
        .clr_i(clr_i), .tick_i(tick_i), .preset_i(preset_i),
        .acc_o(acc_o), .en_o(en_o), .tt_o(tt_o), .dn_o(dn_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic c, input logic t, input logic k);
        cond_i = c; tick_i = t; clr_i = k;
        @(negedge clk);
    endtask

    task automatic run(input logic c, input logic t, input int n);
        for (int i = 0; i < n; i++) cyc(c, t, 1'b0);
    endtask

    task automatic do_reset(input logic [1:0] m, input logic [31:0] p);
        @(negedge clk);
        rst_n = 1'b0; mode_sel = m; preset_i = p;
        cond_i = 1'b0; tick_i = 1'b0; clr_i = 1'b0;
        run(1'b0, 1'b0, 2);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset(2'b00, 32'd5);
        check("R11 acc", acc_o, 0);
        check("R11 en", en_o, 0);
        check("R11 tt", tt_o, 0);
        check("R11 dn", dn_o, 0);
    endtask

    task automatic t_delay_on();
        do_reset(2'b00, 32'd5);
        run(1'b0, 1'b1, 2);
        check("R2 tick without condition acc", acc_o, 0);
        run(1'b1, 1'b1, 4);
        check("R1 acc after 4 ticks", acc_o, 4);
        check("R1 dn before preset", dn_o, 0);
        check("R7 tt while counting", tt_o, 1);
        check("R8 en mirrors condition", en_o, 1);
        cyc(1'b1, 1'b0, 1'b1);
        check("R6 clear ignored in delay-on", acc_o, 4);
        run(1'b1, 1'b0, 2);
        check("R1 no tick holds acc", acc_o, 4);
        cyc(1'b1, 1'b1, 1'b0);
        check("R1 acc at preset", acc_o, 5);
        check("R1 dn at preset", dn_o, 1);
        check("R7 tt off when done", tt_o, 0);
        run(1'b1, 1'b1, 3);
        check("R9 saturates at preset", acc_o, 5);
        cyc(1'b0, 1'b0, 1'b0);
        check("R2 acc cleared on drop", acc_o, 0);
        check("R2 dn cleared on drop", dn_o, 0);
        check("R8 en follows drop", en_o, 0);
        run(1'b1, 1'b1, 4);
        cyc(1'b0, 1'b1, 1'b0);
        run(1'b1, 1'b1, 4);
        check("R2 short pulse no done", dn_o, 0);
        check("R2 short pulse restarts count", acc_o, 4);
    endtask

    task automatic t_delay_off();
        do_reset(2'b01, 32'd5);
        run(1'b0, 1'b1, 3);
        check("R3 idle no done", dn_o, 0);
        check("R3 idle acc", acc_o, 0);
        cyc(1'b1, 1'b0, 1'b0);
        check("R3 done immediate", dn_o, 1);
        check("R3 acc zero while enabled", acc_o, 0);
        check("R7 tt off while enabled", tt_o, 0);
        run(1'b0, 1'b1, 2);
        check("R3 run-down acc", acc_o, 2);
        check("R3 done held in run-down", dn_o, 1);
        check("R7 tt during run-down", tt_o, 1);
        cyc(1'b0, 1'b0, 1'b1);
        check("R6 clear ignored in delay-off", acc_o, 2);
        cyc(1'b1, 1'b0, 1'b0);
        check("R4 retrigger clears acc", acc_o, 0);
        check("R4 retrigger keeps done", dn_o, 1);
        run(1'b0, 1'b1, 4);
        check("R4 run-down restarted", acc_o, 4);
        check("R4 done still held", dn_o, 1);
        cyc(1'b0, 1'b1, 1'b0);
        check("R3 done clears at preset", dn_o, 0);
        check("R3 acc at preset", acc_o, 5);
        check("R7 tt off after run-down", tt_o, 0);
        run(1'b0, 1'b1, 3);
        check("R9 no wrap after run-down", acc_o, 5);
    endtask

    task automatic t_accum();
        do_reset(2'b10, 32'd6);
        run(1'b1, 1'b1, 4);
        check("R5 counting", acc_o, 4);
        run(1'b0, 1'b1, 3);
        check("R5 held while low", acc_o, 4);
        check("R7 tt off while low", tt_o, 0);
        run(1'b1, 1'b1, 2);
        check("R5 resumed to preset", acc_o, 6);
        check("R5 done at preset", dn_o, 1);
        run(1'b0, 1'b1, 2);
        check("R5 done held while low", dn_o, 1);
        check("R9 acc held at preset", acc_o, 6);
        cyc(1'b1, 1'b1, 1'b1);
        check("R6 clear acc", acc_o, 0);
        check("R6 clear done", dn_o, 0);
        run(1'b1, 1'b1, 1);
        check("R5 counts after clear", acc_o, 1);
    endtask

    task automatic t_mode_rules();
        do_reset(2'b11, 32'd5);
        run(1'b1, 1'b1, 3);
        check("R10 mode 11 counts", acc_o, 3);
        cyc(1'b0, 1'b0, 1'b0);
        check("R10 mode 11 acts as delay-on", acc_o, 0);
        do_reset(2'b00, 32'd5);
        mode_sel = 2'b10;
        run(1'b1, 1'b1, 3);
        cyc(1'b0, 1'b0, 1'b0);
        check("R10 mode change after reset ignored", acc_o, 0);
        mode_sel = 2'b01;
        cyc(1'b1, 1'b0, 1'b0);
        check("R10 still delay-on dn", dn_o, 0);
    endtask

    task automatic t_zero_preset();
        do_reset(2'b00, 32'd0);
        cyc(1'b1, 1'b0, 1'b0);
        check("R1 zero preset done", dn_o, 1);
        check("R9 zero preset acc", acc_o, 0);
    endtask

    initial begin
        t_reset_state();
        t_delay_on();
        t_delay_off();
        t_accum();
        t_mode_rules();
        t_zero_preset();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done_flag) begin
            done_flag = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule